// File: doc/BRIEF.md
# Dual-Length Command Frame Receiver with SEC-DED

This block takes a serial command channel, one bit per cycle in which a valid strobe is high, and recovers two kinds of frame from it. A short frame carries one broadcast command byte. A long frame carries a receiver address, an internal/external space select bit, a sub-address and a data byte. A header bit after the start bit selects the frame type. Each frame type has its own Hamming check field, which gives single-error correction and double-error detection.

Long frames pass through an address filter. A frame is delivered only when its address matches the programmed local address, or when its address is zero, which every receiver treats as a broadcast. Results appear on registered outputs with single-cycle pulses that report valid data, a corrected error, an uncorrectable error or a bad stop bit. The block does not store messages. It does not recover bits from the physical line.

Top module: `cmd_frame_rx`

## Requirements
- R1: The line idles at 1. A 0 seen while idle is a start bit. The next bit is the header: 0 selects a short frame and 1 selects a long frame. Every field is sent MSB first. A short frame then carries an 8-bit command and a 5-bit check field, followed by a stop bit of 1. On acceptance, `out_vld` pulses in the cycle after the stop-bit strobe, with `out_long`=0, `out_cmd` set to the command and `out_bcast`=1. A new start bit may follow the stop bit directly.
- R2: A long frame carries, in wire order: a 14-bit address, the E bit, an 8-bit sub-address, an 8-bit data byte, a 7-bit check field and the stop bit. When the address equals `my_addr`, `out_vld` pulses with `out_long`=1, the four fields on `out_addr`/`out_ext`/`out_sub`/`out_data`, and `out_bcast`=0.
- R3: A long frame with address zero is accepted whatever `my_addr` holds, and it sets `out_bcast`=1.
- R4: A long frame with any other address produces no pulse on any output and leaves every field output unchanged. This holds even when the frame carries a correctable error.
- R5: Code definition. Number the protected bits from 0 at the LSB. A short frame protects its command. A long frame protects {address, E, 1, sub-address, data}, a 32-bit word whose reserved bit is not sent on the wire. Data bit j takes the (j+1)-th position, counting upward from 3, that is not a power of two. Hamming bit i is the XOR of the data bits whose position has bit i set. The check field is {overall parity, Hamming bits}, where the overall parity makes data plus check bits even. Any single flipped bit in the data or check field is corrected: the original fields are delivered and `out_corr` pulses together with `out_vld`.
- R6: Two flipped bits in a frame suppress `out_vld` and pulse `err_unc` in the cycle after the stop strobe. All field outputs hold.
- R7: A stop bit of 0 pulses `err_frame` in the cycle after its strobe, with no other pulse. The parser then ignores 0 bits until it has seen a 1.
- R8: Cycles with `bit_vld` low are ignored, whatever `bit_in` carries.
- R9: While `rst` is high and after it is released, all pulses are low and all field outputs are zero. The parser waits for a 1 before it accepts a start bit.
- R10: Every pulse output is high for a single cycle. Field outputs change only when `out_vld` pulses. A short frame updates only `out_cmd`, `out_long` and `out_bcast`. A long frame leaves `out_cmd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe marking a valid line bit |
| bit_in | input | 1 | Serial line bit |
| my_addr | input | 14 | Local receiver address |
| out_vld | output | 1 | Pulse: a frame was accepted |
| out_long | output | 1 | Type of the last accepted frame (1 = long) |
| out_cmd | output | 8 | Command of the last accepted short frame |
| out_addr | output | 14 | Address of the last accepted long frame |
| out_ext | output | 1 | E bit of the last accepted long frame |
| out_sub | output | 8 | Sub-address of the last accepted long frame |
| out_data | output | 8 | Data of the last accepted long frame |
| out_bcast | output | 1 | Last accepted frame was a broadcast |
| out_corr | output | 1 | Pulse: the accepted frame had one corrected bit |
| err_unc | output | 1 | Pulse: uncorrectable frame discarded |
| err_frame | output | 1 | Pulse: stop bit was 0 |

## Verification
A wrong bit counter or shift position moves the stop-bit sample. The error then shows as a missing or extra pulse, or as shifted field values, in the cycle after the expected stop bit, within one frame. A wrong syndrome mapping shows up when a single flipped bit is delivered uncorrected or is reported as uncorrectable. A parser state that leaves its hunt state too early decodes the bits that follow a framing error as a frame. The bench therefore compares every output against a behavioural model in every cycle, so each of these faults is caught in the cycle where it first shows.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_IDLE,
    ST_HDR,
    ST_BODY,
    ST_STOP
  } rx_state_t;

  // Hamming bits needed for dw data bits (overall parity not included).
  function automatic int hamm_bits(input int dw);
    for (int k = 1; k < 32; k++) begin
      if ((1 << k) >= dw + k + 1) return k;
    end
    return 32;
  endfunction

  // Code position of data bit j: the (j+1)-th non-power-of-two from 3 upward.
  function automatic int data_pos(input int j);
    int n;
    n = 0;
    for (int p = 3; p < 1024; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) return p;
        n++;
      end
    end
    return 0;
  endfunction

  // Data bits that feed Hamming bit i.
  function automatic logic [63:0] cover_mask(input int i, input int dw);
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < dw; j++) begin
      if (((data_pos(j) >> i) & 1) == 1) m[j] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/cmdrx_secded.sv
module cmdrx_secded #(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] chk,
  output logic [DW-1:0] dout,
  output logic          fixed,
  output logic          fatal
);
  import cmdrx_pkg::*;

  localparam int K    = CW - 1;
  localparam int MAXP = data_pos(DW - 1);

  logic [K-1:0] calc;
  logic [K-1:0] syn;
  logic         par;

  for (genvar i = 0; i < K; i++) begin : g_chk
    localparam logic [63:0] M = cover_mask(i, DW);
    assign calc[i] = ^(din & M[DW-1:0]);
  end

  assign syn = calc ^ chk[K-1:0];
  assign par = ^{din, chk};

  for (genvar j = 0; j < DW; j++) begin : g_fix
    localparam int P = data_pos(j);
    assign dout[j] = din[j] ^ (par && (syn == K'(P)));
  end

  assign fixed = par && (int'(syn) <= MAXP);
  assign fatal = (!par && (syn != '0)) || (par && (int'(syn) > MAXP));

endmodule

// File: rtl/cmdrx_deser.sv
module cmdrx_deser #(
  parameter int SH_W  = 38,
  parameter int SB    = 13,
  parameter int LB    = 38,
  parameter int CNT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_vld,
  input  logic            bit_in,
  output logic [SH_W-1:0] sh,
  output logic            is_long,
  output logic            end_ok,
  output logic            end_bad
);
  import cmdrx_pkg::*;

  localparam logic [CNT_W-1:0] SCNT = CNT_W'(SB - 1);
  localparam logic [CNT_W-1:0] LCNT = CNT_W'(LB - 1);

  rx_state_t        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      sh      <= '0;
      cnt     <= '0;
      is_long <= 1'b0;
    end else if (bit_vld) begin
      case (st)
        ST_HUNT: if (bit_in) st <= ST_IDLE;
        ST_IDLE: if (!bit_in) st <= ST_HDR;
        ST_HDR: begin
          is_long <= bit_in;
          cnt     <= bit_in ? LCNT : SCNT;
          st      <= ST_BODY;
        end
        ST_BODY: begin
          sh <= {sh[SH_W-2:0], bit_in};
          if (cnt == '0) st <= ST_STOP;
          else           cnt <= cnt - 1'b1;
        end
        ST_STOP: st <= bit_in ? ST_IDLE : ST_HUNT;
        default: st <= ST_HUNT;
      endcase
    end
  end

  assign end_ok  = (st == ST_STOP) && bit_vld && bit_in;
  assign end_bad = (st == ST_STOP) && bit_vld && !bit_in;

  // R8: a cycle without strobe changes neither parser state nor payload
  a_r8_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> ($stable(st) && $stable(sh) && $stable(cnt)));

endmodule

// File: rtl/cmdrx_outreg.sv
module cmdrx_outreg #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 14,
  parameter int SUB_W  = 8,
  parameter int DATA_W = 8,
  parameter int LW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              end_ok,
  input  logic              end_bad,
  input  logic              is_long,
  input  logic [CMD_W-1:0]  s_word,
  input  logic              s_fix,
  input  logic              s_fatal,
  input  logic [LW-1:0]     l_word,
  input  logic              l_fix,
  input  logic              l_fatal,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              out_vld,
  output logic              out_long,
  output logic [CMD_W-1:0]  out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ext,
  output logic [SUB_W-1:0]  out_sub,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bcast,
  output logic              out_corr,
  output logic              err_unc,
  output logic              err_frame
);
  localparam int RES_BIT = DATA_W + SUB_W;

  logic [ADDR_W-1:0] l_addr;
  logic              l_bad;
  logic              hit;

  assign l_addr = l_word[LW-1 -: ADDR_W];
  // A syndrome aimed at the unsent reserved bit means a multi-bit error.
  assign l_bad  = l_fatal || !l_word[RES_BIT];
  assign hit    = (l_addr == my_addr) || (l_addr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_long  <= 1'b0;
      out_cmd   <= '0;
      out_addr  <= '0;
      out_ext   <= 1'b0;
      out_sub   <= '0;
      out_data  <= '0;
      out_bcast <= 1'b0;
      out_corr  <= 1'b0;
      err_unc   <= 1'b0;
      err_frame <= 1'b0;
    end else begin
      out_vld   <= 1'b0;
      out_corr  <= 1'b0;
      err_unc   <= 1'b0;
      err_frame <= end_bad;
      if (end_ok) begin
        if (!is_long) begin
          if (s_fatal) begin
            err_unc <= 1'b1;
          end else begin
            out_vld   <= 1'b1;
            out_corr  <= s_fix;
            out_long  <= 1'b0;
            out_cmd   <= s_word;
            out_bcast <= 1'b1;
          end
        end else if (l_bad) begin
          err_unc <= 1'b1;
        end else if (hit) begin
          out_vld   <= 1'b1;
          out_corr  <= l_fix;
          out_long  <= 1'b1;
          out_addr  <= l_addr;
          out_ext   <= l_word[RES_BIT+1];
          out_sub   <= l_word[DATA_W +: SUB_W];
          out_data  <= l_word[DATA_W-1:0];
          out_bcast <= (l_addr == '0);
        end
      end
    end
  end

  // R10: accept strobe lasts one cycle
  a_r10_vld_pulse: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
  // R6: uncorrectable frames never deliver
  a_r6_unc_no_vld: assert property (@(posedge clk) disable iff (rst)
    err_unc |-> !out_vld);
  // R7: framing error stands alone
  a_r7_frame_alone: assert property (@(posedge clk) disable iff (rst)
    err_frame |-> (!out_vld && !err_unc && !out_corr));
  // R5: correction flag only accompanies a delivered frame
  a_r5_corr_with_vld: assert property (@(posedge clk) disable iff (rst)
    out_corr |-> out_vld);
  // R4: delivered long frames match the local address or are broadcast
  a_r4_addr_filter: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_long) |-> ((out_addr == '0) || (out_addr == $past(my_addr))));
  // R3: broadcast marking of long frames follows the zero address
  a_r3_zero_bcast: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_long) |-> (out_bcast == (out_addr == '0)));

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 14,
  parameter int SUB_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              out_vld,
  output logic              out_long,
  output logic [CMD_W-1:0]  out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ext,
  output logic [SUB_W-1:0]  out_sub,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bcast,
  output logic              out_corr,
  output logic              err_unc,
  output logic              err_frame
);
  import cmdrx_pkg::*;

  localparam int LW    = ADDR_W + 2 + SUB_W + DATA_W;
  localparam int SCW   = hamm_bits(CMD_W) + 1;
  localparam int LCW   = hamm_bits(LW) + 1;
  localparam int SB    = CMD_W + SCW;
  localparam int LB    = ADDR_W + 1 + SUB_W + DATA_W + LCW;
  localparam int SH_W  = (LB > SB) ? LB : SB;
  localparam int CNT_W = $clog2(SH_W);

  logic [SH_W-1:0]  sh;
  logic             is_long, end_ok, end_bad;
  logic [LW-1:0]    l_in, l_word;
  logic [CMD_W-1:0] s_word;
  logic             s_fix, s_fatal, l_fix, l_fatal;

  cmdrx_deser #(.SH_W(SH_W), .SB(SB), .LB(LB), .CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .sh(sh), .is_long(is_long), .end_ok(end_ok), .end_bad(end_bad)
  );

  assign l_in = {sh[LB-1 -: ADDR_W], sh[LCW+DATA_W+SUB_W], 1'b1,
                 sh[LCW+DATA_W +: SUB_W], sh[LCW +: DATA_W]};

  cmdrx_secded #(.DW(CMD_W), .CW(SCW)) u_dec_short (
    .din(sh[SCW +: CMD_W]), .chk(sh[SCW-1:0]),
    .dout(s_word), .fixed(s_fix), .fatal(s_fatal)
  );

  cmdrx_secded #(.DW(LW), .CW(LCW)) u_dec_long (
    .din(l_in), .chk(sh[LCW-1:0]),
    .dout(l_word), .fixed(l_fix), .fatal(l_fatal)
  );

  cmdrx_outreg #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .SUB_W(SUB_W),
                 .DATA_W(DATA_W), .LW(LW)) u_out (
    .clk(clk), .rst(rst), .end_ok(end_ok), .end_bad(end_bad),
    .is_long(is_long), .s_word(s_word), .s_fix(s_fix), .s_fatal(s_fatal),
    .l_word(l_word), .l_fix(l_fix), .l_fatal(l_fatal), .my_addr(my_addr),
    .out_vld(out_vld), .out_long(out_long), .out_cmd(out_cmd),
    .out_addr(out_addr), .out_ext(out_ext), .out_sub(out_sub),
    .out_data(out_data), .out_bcast(out_bcast), .out_corr(out_corr),
    .err_unc(err_unc), .err_frame(err_frame)
  );

endmodule

// File: tb/cmd_frame_rx_tb.sv
module cmd_frame_rx_tb;

  localparam logic [13:0] MY = 14'h2A5C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b1;
  logic [13:0] my_addr = MY;
  logic        out_vld, out_long, out_ext, out_bcast, out_corr, err_unc, err_frame;
  logic [7:0]  out_cmd, out_sub, out_data;
  logic [13:0] out_addr;

  int checks = 0;
  int errors = 0;

  // expected pulses for the coming sample and held field values
  logic        p_vld = 0, p_unc = 0, p_frm = 0, p_corr = 0;
  logic        h_long = 0, h_ext = 0, h_bcast = 0;
  logic [7:0]  h_cmd = 0, h_sub = 0, h_data = 0;
  logic [13:0] h_addr = 0;
  string       chk_tag = "R9";

  always #10 clk = ~clk;

  cmd_frame_rx u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .my_addr(my_addr),
    .out_vld(out_vld), .out_long(out_long), .out_cmd(out_cmd), .out_addr(out_addr),
    .out_ext(out_ext), .out_sub(out_sub), .out_data(out_data), .out_bcast(out_bcast),
    .out_corr(out_corr), .err_unc(err_unc), .err_frame(err_frame)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(chk_tag, "out_vld", 32'(out_vld), 32'(p_vld));
    check(chk_tag, "err_unc", 32'(err_unc), 32'(p_unc));
    check(chk_tag, "err_frame", 32'(err_frame), 32'(p_frm));
    check(chk_tag, "out_corr", 32'(out_corr), 32'(p_corr));
    check(chk_tag, "out_long", 32'(out_long), 32'(h_long));
    check(chk_tag, "out_cmd", 32'(out_cmd), 32'(h_cmd));
    check(chk_tag, "out_addr", 32'(out_addr), 32'(h_addr));
    check(chk_tag, "out_ext", 32'(out_ext), 32'(h_ext));
    check(chk_tag, "out_sub", 32'(out_sub), 32'(h_sub));
    check(chk_tag, "out_data", 32'(out_data), 32'(h_data));
    check(chk_tag, "out_bcast", 32'(out_bcast), 32'(h_bcast));
  endtask

  // one cycle: check what the last edge produced, then drive the next bit
  task automatic tick(input logic v, input logic b);
    @(negedge clk);
    compare_all();
    bit_vld = v;
    bit_in  = b;
    p_vld = 0; p_unc = 0; p_frm = 0; p_corr = 0;
    chk_tag = "R10";
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b1);
  endtask

  // check field per R5: XOR of positions of set data bits, plus even parity on top
  function automatic logic [6:0] encode(input logic [31:0] w, input int dw, input int k);
    logic [6:0] c;
    int p;
    c = '0;
    p = 3;
    for (int j = 0; j < dw; j++) begin
      while ((p & (p - 1)) == 0) p++;
      if (w[j]) c = c ^ 7'(p);
      p++;
    end
    c = c & 7'((1 << k) - 1);
    c[k] = (^w) ^ (^c);
    return c;
  endfunction

  task automatic send_frame(input logic lng, input logic [13:0] a, input logic e,
                            input logic [7:0] sub, input logic [7:0] d,
                            input int f1, input int f2, input logic stop_v,
                            input logic gaps, input string tag);
    logic q[$];
    logic [6:0]  c;
    int nflip;
    q.push_back(1'b0);
    q.push_back(lng);
    if (lng) begin
      c = encode({a, e, 1'b1, sub, d}, 32, 6);
      for (int i = 13; i >= 0; i--) q.push_back(a[i]);
      q.push_back(e);
      for (int i = 7; i >= 0; i--) q.push_back(sub[i]);
      for (int i = 7; i >= 0; i--) q.push_back(d[i]);
      for (int i = 6; i >= 0; i--) q.push_back(c[i]);
    end else begin
      c = encode({24'b0, d}, 8, 4);
      for (int i = 7; i >= 0; i--) q.push_back(d[i]);
      for (int i = 4; i >= 0; i--) q.push_back(c[i]);
    end
    q.push_back(stop_v);
    if (f1 >= 0) q[f1] = ~q[f1];
    if (f2 >= 0) q[f2] = ~q[f2];
    foreach (q[i]) begin
      if (gaps) tick(1'b0, ~q[i]);
      tick(1'b1, q[i]);
    end
    nflip = (f1 >= 0 ? 1 : 0) + (f2 >= 0 ? 1 : 0);
    chk_tag = tag;
    if (!stop_v) begin
      p_frm = 1;
    end else if (nflip == 2) begin
      p_unc = 1;
    end else if (!lng) begin
      p_vld = 1; p_corr = (nflip == 1);
      h_long = 0; h_cmd = d; h_bcast = 1;
    end else if (a == my_addr || a == 14'd0) begin
      p_vld = 1; p_corr = (nflip == 1);
      h_long = 1; h_addr = a; h_ext = e; h_sub = sub; h_data = d;
      h_bcast = (a == 14'd0);
    end
  endtask

  initial begin
    // R9: reset state
    rst = 1'b1;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk_tag = "R9";
    tick(1'b1, 1'b0);   // a 0 under reset is no start
    @(negedge clk);
    rst = 1'b0;
    chk_tag = "R9";
    tick(1'b1, 1'b1);
    idle(3);
    // R1: short frames, including back to back
    send_frame(1'b0, 14'd0, 1'b0, 8'h00, 8'hC3, -1, -1, 1'b1, 1'b0, "R1");
    send_frame(1'b0, 14'd0, 1'b0, 8'h00, 8'h5A, -1, -1, 1'b1, 1'b0, "R1");
    idle(2);
    // R2: long frame to the local address
    send_frame(1'b1, MY, 1'b1, 8'h9E, 8'h71, -1, -1, 1'b1, 1'b0, "R2");
    idle(2);
    // R3: long broadcast
    send_frame(1'b1, 14'd0, 1'b0, 8'h13, 8'hE4, -1, -1, 1'b1, 1'b0, "R3");
    idle(1);
    // R4: foreign address, clean and with one error
    send_frame(1'b1, 14'h1234, 1'b1, 8'hAA, 8'h55, -1, -1, 1'b1, 1'b0, "R4");
    idle(1);
    send_frame(1'b1, 14'h0001, 1'b0, 8'h0F, 8'hF0, 20, -1, 1'b1, 1'b0, "R4");
    idle(1);
    // R5: single errors in data, Hamming and overall parity bits
    send_frame(1'b0, 14'd0, 1'b0, 8'h00, 8'h3C, 4, -1, 1'b1, 1'b0, "R5");
    idle(1);
    send_frame(1'b0, 14'd0, 1'b0, 8'h00, 8'h81, 10, -1, 1'b1, 1'b0, "R5");
    idle(1);
    send_frame(1'b1, MY, 1'b0, 8'h42, 8'h24, 3, -1, 1'b1, 1'b0, "R5");
    idle(1);
    send_frame(1'b1, 14'd0, 1'b1, 8'h66, 8'h99, 37, -1, 1'b1, 1'b0, "R5");
    idle(1);
    send_frame(1'b1, MY, 1'b1, 8'h01, 8'h80, 33, -1, 1'b1, 1'b0, "R5");
    idle(1);
    // R6: double errors
    send_frame(1'b0, 14'd0, 1'b0, 8'h00, 8'h77, 2, 9, 1'b1, 1'b0, "R6");
    idle(1);
    send_frame(1'b1, MY, 1'b0, 8'hDE, 8'hAD, 16, 33, 1'b1, 1'b0, "R6");
    idle(1);
    send_frame(1'b1, MY, 1'b1, 8'h12, 8'h34, 5, 28, 1'b1, 1'b0, "R6");
    idle(1);
    // R7: bad stop bit, then a 0 that must not start a frame
    send_frame(1'b1, MY, 1'b0, 8'hBE, 8'hEF, -1, -1, 1'b0, 1'b0, "R7");
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    send_frame(1'b0, 14'd0, 1'b0, 8'h00, 8'hA7, -1, -1, 1'b1, 1'b0, "R7");
    idle(1);
    // R8: strobe gaps carrying inverted junk
    send_frame(1'b1, MY, 1'b0, 8'hC8, 8'h3B, -1, -1, 1'b1, 1'b1, "R8");
    idle(1);
    send_frame(1'b0, 14'd0, 1'b0, 8'h00, 8'h0E, -1, -1, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule